// File: doc/BRIEF.md
# Service-Sequence Watchdog Timer

This block is a memory-mapped watchdog for a system on chip. Software programs a 16-bit reload value into the control word and sets the enable bit. From then on a down-counter runs, either once per clock or once every 2048 clocks. Software keeps the counter from running out by writing two fixed 16-bit keys, in order, to the service register.

If the counter runs out, the block pulses one of two outputs for one clock. A control bit chooses between a system reset request and a non-maskable interrupt request. The control word also holds a bus monitor enable, a bus monitor timing field in units of 8 clocks (up to 2040 clocks) and a debug freeze bit. These fields are only stored and read back.

The register bus is a simple single-cycle port: a write strobe, a byte offset and write data. Read data is combinational from the offset. The service register takes its 16-bit value on `bus_wdata[15:0]`.

Top module: `svc_watchdog`

## Requirements
- R1: A synchronous active-high reset clears the control word and the counter to zero, drops both expiry outputs, and returns the service sequence to idle. A second key written after reset does not reload the counter.
- R2: The control word at offset 0x4 holds the following fields. All written fields read back exactly as written, and bits 6:4 always read zero.
  - bits 31:16: reload count
  - bits 15:8: bus monitor timing
  - bit 7: bus monitor enable
  - bit 3: freeze
  - bit 2: enable
  - bit 1: action (1 = reset request, 0 = interrupt request)
  - bit 0: prescale
- R3: Writing 0x556C and then 0xAA39 to offset 0xE reloads the counter from the reload count on the edge of the second write. That reload also suppresses any expiry due in the same cycle.
- R4: Any other value written to offset 0xE returns the service sequence to idle without a reload. This covers a wrong second key and a non-first key written while idle. Writes to other offsets leave a half-finished sequence intact.
- R5: While enabled, a tick that finds the counter at zero reloads it from the reload count. The clock after that tick, it pulses `rst_req` if the action bit is 1, or `nmi_req` if the action bit is 0, for exactly one clock. The two outputs are never high together.
- R6: Offset 0x8 reads `{16'h0, counter}`. Writes to offset 0x8 are ignored. Offsets 0x0 and 0xC read zero.
- R7: While enabled with prescale clear, the counter drops by one every clock. With prescale set, it drops once every 2048 enabled clocks, counted from enabling or servicing.
- R8: A control write that sets the enable bit while it was clear loads the counter from the written reload count. While disabled, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data; the service key is on bits 15:0 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| rst_req | output | 1 | One-clock system reset request on expiry |
| nmi_req | output | 1 | One-clock non-maskable interrupt request on expiry |

## Verification
The assertions assume that a bus write lasts one clock and names one offset. A control write and a service write therefore never land in the same cycle. They also assume the bus is quiet while reset is high. The stimulus issues each write as a single strobed clock, keeps `bus_wr` low through both resets, and changes inputs only on the falling edge. A behavioural model in the bench follows every clock and covers both actions, both prescale settings, the broken and interleaved key orders, and a reset that lands between the two keys.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int TC_W   = 16;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_SVC  = 4'hE;

    localparam logic [15:0] KEY_FIRST  = 16'h556C;
    localparam logic [15:0] KEY_SECOND = 16'hAA39;

    typedef struct packed {
        logic [TC_W-1:0] tc;
        logic [7:0]      mon_time;
        logic            mon_en;
        logic [2:0]      unused;
        logic            freeze;
        logic            en;
        logic            act_rst;
        logic            pre;
    } wd_ctrl_t;

    typedef enum logic {
        SVC_IDLE  = 1'b0,
        SVC_ARMED = 1'b1
    } svc_state_e;

    function automatic wd_ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        wd_ctrl_t c;
        c        = wd_ctrl_t'(w);
        c.unused = '0;
        return c;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output wd_ctrl_t            ctrl_q,
    output logic                arm_load,
    output logic [TC_W-1:0]     arm_tc
);
    wd_ctrl_t ctrl_nxt;
    logic     wr_ctrl;

    assign wr_ctrl  = bus_wr && (bus_addr == OFF_CTRL);
    assign ctrl_nxt = ctrl_from_word(bus_wdata);
    assign arm_load = wr_ctrl && ctrl_nxt.en && !ctrl_q.en;
    assign arm_tc   = ctrl_nxt.tc;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_nxt;
        end
    end
endmodule

// File: rtl/wdog_svc.sv
module wdog_svc
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       key,
    output logic              kick
);
    svc_state_e state_q, state_nxt;
    logic       svc_wr;

    assign svc_wr = bus_wr && (bus_addr == OFF_SVC);

    always_comb begin
        state_nxt = state_q;
        kick      = 1'b0;
        if (svc_wr) begin
            case (state_q)
                SVC_IDLE:  state_nxt = (key == KEY_FIRST) ? SVC_ARMED : SVC_IDLE;
                SVC_ARMED: begin
                    kick      = (key == KEY_SECOND);
                    state_nxt = SVC_IDLE;
                end
                default:   state_nxt = SVC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SVC_IDLE;
        else     state_q <= state_nxt;
    end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int PRESCALE_DIV = 2048
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            pre,
    input  logic            act_rst,
    input  logic [TC_W-1:0] tc,
    input  logic            arm_load,
    input  logic [TC_W-1:0] arm_tc,
    input  logic            kick,
    output logic [TC_W-1:0] cnt_q,
    output logic            rst_req,
    output logic            nmi_req
);
    logic tick;
    logic expire;

    generate
        if (PRESCALE_DIV > 1) begin : g_presc
            localparam int            PW    = $clog2(PRESCALE_DIV);
            localparam logic [PW-1:0] PLAST = PW'(PRESCALE_DIV - 1);
            logic [PW-1:0] presc_q;

            always_ff @(posedge clk) begin
                if (rst || arm_load || kick || !en || !pre) begin
                    presc_q <= '0;
                end else if (presc_q == PLAST) begin
                    presc_q <= '0;
                end else begin
                    presc_q <= presc_q + 1'b1;
                end
            end

            assign tick = en && (!pre || (presc_q == PLAST));
        end else begin : g_nopresc
            logic unused_pre;
            assign unused_pre = pre;
            assign tick       = en;
        end
    endgenerate

    assign expire = tick && (cnt_q == '0) && !arm_load && !kick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (arm_load) begin
            cnt_q <= arm_tc;
        end else if (kick) begin
            cnt_q <= tc;
        end else if (tick) begin
            cnt_q <= (cnt_q == '0) ? tc : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req <= 1'b0;
            nmi_req <= 1'b0;
        end else begin
            rst_req <= expire && act_rst;
            nmi_req <= expire && !act_rst;
        end
    end
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import wdog_pkg::*;
#(
    parameter int PRESCALE_DIV = 2048
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        rst_req,
    output logic        nmi_req
);
    wd_ctrl_t        ctrl_q;
    logic            arm_load;
    logic [TC_W-1:0] arm_tc;
    logic            kick;
    logic [TC_W-1:0] cnt_q;
    logic            ctrl_en, ctrl_pre;
    logic [TC_W-1:0] ctrl_tc;

    assign ctrl_en  = ctrl_q.en;
    assign ctrl_pre = ctrl_q.pre;
    assign ctrl_tc  = ctrl_q.tc;

    wdog_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctrl_q    (ctrl_q),
        .arm_load  (arm_load),
        .arm_tc    (arm_tc)
    );

    wdog_svc u_svc (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .key      (bus_wdata[15:0]),
        .kick     (kick)
    );

    wdog_core #(.PRESCALE_DIV(PRESCALE_DIV)) u_core (
        .clk      (clk),
        .rst      (rst),
        .en       (ctrl_en),
        .pre      (ctrl_pre),
        .act_rst  (ctrl_q.act_rst),
        .tc       (ctrl_tc),
        .arm_load (arm_load),
        .arm_tc   (arm_tc),
        .kick     (kick),
        .cnt_q    (cnt_q),
        .rst_req  (rst_req),
        .nmi_req  (nmi_req)
    );

    always_comb begin
        case (bus_addr)
            OFF_CTRL: bus_rdata = ctrl_q;
            OFF_CNT:  bus_rdata = {{(DATA_W-TC_W){1'b0}}, cnt_q};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic        pre,
    input logic [15:0] tc,
    input logic [15:0] cnt,
    input logic        arm,
    input logic [15:0] arm_tc,
    input logic        kick,
    input logic        rst_req,
    input logic        nmi_req
);
    assert_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && nmi_req));

    assert_needs_en_R5: assert property (@(posedge clk) disable iff (rst)
        (rst_req || nmi_req) |-> $past(en));

    assert_kick_reload_R3: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt == $past(tc)));

    assert_arm_load_R8: assert property (@(posedge clk) disable iff (rst)
        arm |=> (cnt == $past(arm_tc)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!en && !arm && !kick) |=> (cnt == $past(cnt)));

    assert_decrement_R7: assert property (@(posedge clk) disable iff (rst)
        (en && !pre && !arm && !kick && cnt != 16'h0) |=> (cnt == $past(cnt) - 16'd1));
endmodule

bind svc_watchdog wdog_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (ctrl_en),
    .pre     (ctrl_pre),
    .tc      (ctrl_tc),
    .cnt     (cnt_q),
    .arm     (arm_load),
    .arm_tc  (arm_tc),
    .kick    (kick),
    .rst_req (rst_req),
    .nmi_req (nmi_req)
);

// File: tb/sim_svc_watchdog.sv
`timescale 1ns/1ps
module sim_svc_watchdog;
    localparam int DIV = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req, nmi_req;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    svc_watchdog u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req),
        .nmi_req   (nmi_req)
    );

    // behavioural reference
    logic [31:0] m_ctrl;
    int          m_cnt, m_presc;
    bit          m_armed, m_rst, m_nmi;

    always @(posedge clk) begin
        bit en, pre, arm, kick, tick;
        int tc;
        en = m_ctrl[2]; pre = m_ctrl[0]; tc = int'(m_ctrl[31:16]);
        if (rst) begin
            m_ctrl = 0; m_cnt = 0; m_presc = 0; m_armed = 0; m_rst = 0; m_nmi = 0;
        end else begin
            arm  = bus_wr && bus_addr == 4'h4 && bus_wdata[2] && !en;
            kick = bus_wr && bus_addr == 4'hE && m_armed && bus_wdata[15:0] == 16'hAA39;
            tick = en && (!pre || m_presc == DIV - 1);
            m_rst = tick && m_cnt == 0 && !arm && !kick && m_ctrl[1];
            m_nmi = tick && m_cnt == 0 && !arm && !kick && !m_ctrl[1];
            if (arm)       m_cnt = int'(bus_wdata[31:16]);
            else if (kick) m_cnt = tc;
            else if (tick) m_cnt = (m_cnt == 0) ? tc : m_cnt - 1;
            if (arm || kick || !en || !pre || m_presc == DIV - 1) m_presc = 0;
            else m_presc++;
            if (bus_wr && bus_addr == 4'hE)
                m_armed = !m_armed && bus_wdata[15:0] == 16'h556C;
            if (bus_wr && bus_addr == 4'h4) m_ctrl = bus_wdata & 32'hFFFF_FF8F;
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        if (a == 4'h4) return m_ctrl;
        if (a == 4'h8) return 32'(m_cnt);
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        check(bus_addr == 4'h4 ? "R2 model control read" : "R6 model register read",
              bus_rdata, m_read(bus_addr));
        check("R5 model rst_req", 32'(rst_req), 32'(m_rst));
        check("R5 model nmi_req", 32'(nmi_req), 32'(m_nmi));
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input string tag, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        check(tag, bus_rdata, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            vectors++;
            $display("FAIL watchdog expired, all requirements: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        peek("R1 control after reset", 4'h4, 32'h0);
        peek("R1 counter after reset", 4'h8, 32'h0);
        check("R1 outputs after reset", {30'h0, rst_req, nmi_req}, 32'h0);

        wr(4'h4, 32'h0005_A5FA);
        peek("R2 control readback", 4'h4, 32'h0005_A58A);
        peek("R8 disabled counter holds", 4'h8, 32'h0);

        wr(4'h8, 32'h0000_1234);
        peek("R6 count write ignored", 4'h8, 32'h0);
        peek("R6 offset 0 reads zero", 4'h0, 32'h0);
        peek("R6 offset C reads zero", 4'hC, 32'h0);

        wr(4'h4, 32'h0005_A58E);
        peek("R8 enable loads reload count", 4'h8, 32'd5);
        idle(2);
        peek("R7 decrement every clock", 4'h8, 32'd3);
        idle(3);
        peek("R5 counter at zero", 4'h8, 32'd0);
        check("R5 no early reset request", 32'(rst_req), 32'd0);
        idle(1);
        check("R5 reset request pulse", {30'h0, rst_req, nmi_req}, 32'h2);
        peek("R5 reload after expiry", 4'h8, 32'd5);
        idle(1);
        check("R5 pulse lasts one clock", 32'(rst_req), 32'd0);

        wr(4'hE, 32'h0000_556C);
        wr(4'hE, 32'h0000_AA39);
        peek("R3 service reload", 4'h8, 32'd5);

        wr(4'hE, 32'h0000_556C);
        wr(4'hE, 32'h0000_1234);
        wr(4'hE, 32'h0000_AA39);
        peek("R4 broken sequence no reload", 4'h8, 32'd2);
        wr(4'hE, 32'h0000_556C);
        wr(4'h8, 32'h0000_0000);
        wr(4'hE, 32'h0000_AA39);
        peek("R4 other offset keeps sequence", 4'h8, 32'd5);
        check("R3 service beats expiry", 32'(rst_req), 32'd0);

        wr(4'h4, 32'h0005_A58A);
        idle(5);
        peek("R8 disable holds counter", 4'h8, 32'd4);

        wr(4'h4, 32'h0002_0004);
        idle(3);
        check("R5 interrupt request pulse", {30'h0, rst_req, nmi_req}, 32'h1);
        peek("R5 reload in interrupt mode", 4'h8, 32'd2);

        wr(4'h4, 32'h0000_0000);
        wr(4'h4, 32'h0001_0005);
        idle(DIV - 1);
        peek("R7 prescaled hold", 4'h8, 32'd1);
        idle(1);
        peek("R7 prescaled decrement", 4'h8, 32'd0);
        idle(DIV - 1);
        check("R7 no early prescaled expiry", 32'(nmi_req), 32'd0);
        idle(1);
        check("R7 prescaled expiry", 32'(nmi_req), 32'd1);

        wr(4'hE, 32'h0000_556C);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        peek("R1 control cleared mid-run", 4'h4, 32'h0);
        peek("R1 counter cleared mid-run", 4'h8, 32'h0);
        wr(4'h4, 32'h0009_0004);
        idle(1);
        wr(4'hE, 32'h0000_AA39);
        peek("R1 sequence idle after reset", 4'h8, 32'd7);

        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule